// File: doc/BRIEF.md
# Multi-Rail Supply Sequencer with Latched Protection

This block is the digital control core of a multi-rail supply. When its enable input goes high and the supply is above the undervoltage threshold, it turns on the positive-rail converter at once, with a soft-start (reduced current limit) indication. A fixed number of timebase ticks later, it turns on the negative-rail converter. An auxiliary rail has its own request input and does not take part in this sequence.

While the rails run, the block watches digital flags from external comparators: positive rail below threshold, negative rail drifted above its target, over-temperature, and undervoltage. A rail flag must stay high for a qualified number of ticks before it trips. Over-temperature trips at once. A trip moves the block into a latched shutdown. In that state all converters are off, the outputs are disconnected and discharge is asserted. Two events clear the latch: an undervoltage event, or the enable going low and then high again.

The block uses a 1 µs tick input as its timebase. Both the start delay and the fault qualification time are parameters counted in ticks.

Top module: `supply_seq`

## Requirements
- R1: After reset, and whenever the block is off, these outputs hold: `state_o`=0 (off), `cause_o`=0, positive/negative enables low, soft-start low, connect low, discharge high. State codes are: 0 off, 1 positive-start, 2 running, 3 fault-latched.
- R2: With undervoltage low, a high enable sampled in the off state moves the block to positive-start on the next clock. In positive-start, `pos_en_o`, `pos_softstart_o` and `rail_connect_o` are high, and `neg_en_o` and `discharge_o` are low.
- R3: Positive-start lasts exactly START_TICKS ticks. The block moves to running on the clock that samples the START_TICKS-th tick. In running, `neg_en_o` is high and `pos_softstart_o` is low.
- R4: In running, if `pos_low_i` is high on FAULT_TICKS consecutive ticks without dropping in between, the block latches a fault with `cause_o`=1.
- R5: In running, if `neg_high_i` is held the same way, the block latches a fault with `cause_o`=2.
- R6: When a rail fault flag drops, its qualification count restarts from zero. After that, a further FAULT_TICKS ticks with the flag high are needed to trip.
- R7: Over-temperature sampled in positive-start or running latches a fault on the next clock with `cause_o`=3, without waiting for a tick. Cause priority on the same cycle is over-temperature, then positive rail, then negative rail.
- R8: In the fault-latched state, both converter enables and connect are low and discharge is high. The state and cause hold while enable stays high and undervoltage stays low, even after every fault flag clears.
- R9: Enable low drives any state to off on the next clock. From a latched fault, a later high enable starts the sequence again.
- R10: Undervoltage high forces off (clearing any latch) on the next clock. It also blocks start-up while it stays high. When it releases with enable high, start-up begins.
- R11: `aux_en_o` follows `aux_req_i` one clock later. Undervoltage forces it low, and so does an over-temperature latch. It does not depend on the main enable or the rail state.
- R12: The rail fault flags have no effect outside running. Time spent with a flag high during positive-start does not count toward qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-clock timebase pulse (nominally every 1 µs) |
| ctrl_en_i | input | 1 | Main enable for the positive/negative sequence |
| uvlo_i | input | 1 | Undervoltage lockout flag, high = supply too low |
| aux_req_i | input | 1 | Auxiliary rail enable request |
| pos_low_i | input | 1 | Positive rail below threshold flag |
| neg_high_i | input | 1 | Negative rail drifted above target flag |
| ot_i | input | 1 | Over-temperature flag |
| pos_en_o | output | 1 | Positive converter enable |
| pos_softstart_o | output | 1 | Reduced current limit indication |
| neg_en_o | output | 1 | Negative converter enable |
| aux_en_o | output | 1 | Auxiliary converter enable |
| rail_connect_o | output | 1 | Output disconnect switches closed |
| discharge_o | output | 1 | Output discharge active |
| state_o | output | 2 | 0 off, 1 positive-start, 2 running, 3 fault-latched |
| cause_o | output | 2 | 0 none, 1 positive low, 2 negative high, 3 over-temperature |

## Verification
The bench builds the block with START_TICKS=20 and FAULT_TICKS=5 and drives the tick input by hand. This makes the exact boundary ticks of both counters cheap to reach: one tick before the start delay ends, one tick before a trip, and a flag that drops a tick short of tripping. The start delay is longer than the qualification time. As a result, a flag held high through the whole of positive-start would trip at once if start-up time were wrongly counted.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_START = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    CS_NONE = 2'd0,
    CS_POS  = 2'd1,
    CS_NEG  = 2'd2,
    CS_OT   = 2'd3
  } seq_cause_t;

  localparam int unsigned NUM_RAIL_FLAGS = 2;
  localparam int unsigned FLAG_POS = 0;
  localparam int unsigned FLAG_NEG = 1;
endpackage

// File: rtl/seq_tick_timer.sv
module seq_tick_timer #(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic hit
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign hit = run && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (hit) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/seq_fault_qual.sv
module seq_fault_qual
  import supply_seq_pkg::*;
#(
  parameter int unsigned QUAL_TICKS = 3000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      armed,
  input  logic                      tick,
  input  logic [NUM_RAIL_FLAGS-1:0] flags,
  output logic [NUM_RAIL_FLAGS-1:0] trip
);
  for (genvar g = 0; g < NUM_RAIL_FLAGS; g++) begin : g_qual
    seq_tick_timer #(.LIMIT(QUAL_TICKS)) u_tmr (
      .clk  (clk),
      .rst  (rst),
      .run  (armed && flags[g]),
      .tick (tick),
      .hit  (trip[g])
    );
  end
endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
  import supply_seq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      uvlo,
  input  logic                      ot,
  input  logic                      aux_req,
  input  logic                      start_done,
  input  logic [NUM_RAIL_FLAGS-1:0] rail_trip,
  output seq_state_t                state_q,
  output seq_cause_t                cause_q,
  output logic                      pos_en_q,
  output logic                      softstart_q,
  output logic                      neg_en_q,
  output logic                      connect_q,
  output logic                      discharge_q,
  output logic                      aux_en_q
);
  seq_state_t nxt;
  seq_cause_t nxt_cause;

  always_comb begin
    nxt       = state_q;
    nxt_cause = cause_q;
    if (uvlo) begin
      nxt = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: if (en) nxt = ST_START;
        ST_START: begin
          if (!en) nxt = ST_OFF;
          else if (ot) begin
            nxt = ST_FAULT; nxt_cause = CS_OT;
          end else if (start_done) nxt = ST_RUN;
        end
        ST_RUN: begin
          if (!en) nxt = ST_OFF;
          else if (ot) begin
            nxt = ST_FAULT; nxt_cause = CS_OT;
          end else if (rail_trip[FLAG_POS]) begin
            nxt = ST_FAULT; nxt_cause = CS_POS;
          end else if (rail_trip[FLAG_NEG]) begin
            nxt = ST_FAULT; nxt_cause = CS_NEG;
          end
        end
        ST_FAULT: if (!en) nxt = ST_OFF;
        default: nxt = ST_OFF;
      endcase
    end
    if (nxt != ST_FAULT) nxt_cause = CS_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_OFF;
      cause_q     <= CS_NONE;
      pos_en_q    <= 1'b0;
      softstart_q <= 1'b0;
      neg_en_q    <= 1'b0;
      connect_q   <= 1'b0;
      discharge_q <= 1'b1;
      aux_en_q    <= 1'b0;
    end else begin
      state_q     <= nxt;
      cause_q     <= nxt_cause;
      pos_en_q    <= (nxt == ST_START) || (nxt == ST_RUN);
      softstart_q <= (nxt == ST_START);
      neg_en_q    <= (nxt == ST_RUN);
      connect_q   <= (nxt == ST_START) || (nxt == ST_RUN);
      discharge_q <= (nxt == ST_OFF) || (nxt == ST_FAULT);
      aux_en_q    <= aux_req && !uvlo && (nxt_cause != CS_OT);
    end
  end
endmodule

// File: rtl/supply_seq.sv
module supply_seq
  import supply_seq_pkg::*;
#(
  parameter int unsigned START_TICKS = 10000,
  parameter int unsigned FAULT_TICKS = 3000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       ctrl_en_i,
  input  logic       uvlo_i,
  input  logic       aux_req_i,
  input  logic       pos_low_i,
  input  logic       neg_high_i,
  input  logic       ot_i,
  output logic       pos_en_o,
  output logic       pos_softstart_o,
  output logic       neg_en_o,
  output logic       aux_en_o,
  output logic       rail_connect_o,
  output logic       discharge_o,
  output logic [1:0] state_o,
  output logic [1:0] cause_o
);
  seq_state_t                st;
  seq_cause_t                cs;
  logic                      start_done;
  logic [NUM_RAIL_FLAGS-1:0] rail_flags;
  logic [NUM_RAIL_FLAGS-1:0] rail_trip;

  assign rail_flags[FLAG_POS] = pos_low_i;
  assign rail_flags[FLAG_NEG] = neg_high_i;

  seq_tick_timer #(.LIMIT(START_TICKS)) u_start_dly (
    .clk  (clk),
    .rst  (rst),
    .run  (st == ST_START),
    .tick (tick_i),
    .hit  (start_done)
  );

  seq_fault_qual #(.QUAL_TICKS(FAULT_TICKS)) u_qual (
    .clk   (clk),
    .rst   (rst),
    .armed (st == ST_RUN),
    .tick  (tick_i),
    .flags (rail_flags),
    .trip  (rail_trip)
  );

  seq_ctrl_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .en          (ctrl_en_i),
    .uvlo        (uvlo_i),
    .ot          (ot_i),
    .aux_req     (aux_req_i),
    .start_done  (start_done),
    .rail_trip   (rail_trip),
    .state_q     (st),
    .cause_q     (cs),
    .pos_en_q    (pos_en_o),
    .softstart_q (pos_softstart_o),
    .neg_en_q    (neg_en_o),
    .connect_q   (rail_connect_o),
    .discharge_q (discharge_o),
    .aux_en_q    (aux_en_o)
  );

  assign state_o = st;
  assign cause_o = cs;
endmodule

// File: rtl/supply_seq_chk.sv
module supply_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_i,
  input logic       ctrl_en_i,
  input logic       uvlo_i,
  input logic       pos_low_i,
  input logic       neg_high_i,
  input logic       ot_i,
  input logic       pos_en_o,
  input logic       neg_en_o,
  input logic       rail_connect_o,
  input logic       discharge_o,
  input logic [1:0] state_o,
  input logic [1:0] cause_o
);
  p_start_needs_enable_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(pos_en_o) |-> ($past(ctrl_en_i) && !$past(uvlo_i)));

  p_neg_after_tick_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(neg_en_o) |-> ($past(state_o) == 2'd1 && $past(tick_i)));

  p_pos_trip_cause_r4: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd3 && cause_o == 2'd1) && $past(state_o) == 2'd2
      |-> ($past(pos_low_i) && $past(tick_i)));

  p_neg_trip_cause_r5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd3 && cause_o == 2'd2) && $past(state_o) == 2'd2
      |-> ($past(neg_high_i) && $past(tick_i)));

  p_ot_trips_r7: assert property (@(posedge clk) disable iff (rst)
    (ot_i && ctrl_en_i && !uvlo_i && (state_o == 2'd1 || state_o == 2'd2))
      |=> (state_o == 2'd3 && cause_o == 2'd3));

  p_latch_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd3 && ctrl_en_i && !uvlo_i) |=> (state_o == 2'd3 && $stable(cause_o)));

  p_fault_safe_r8: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd3) |-> (!pos_en_o && !neg_en_o && !rail_connect_o && discharge_o));

  p_disable_off_r9: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en_i) |=> (state_o == 2'd0));

  p_uvlo_off_r10: assert property (@(posedge clk) disable iff (rst)
    uvlo_i |=> (state_o == 2'd0 && cause_o == 2'd0));
endmodule

bind supply_seq supply_seq_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .tick_i         (tick_i),
  .ctrl_en_i      (ctrl_en_i),
  .uvlo_i         (uvlo_i),
  .pos_low_i      (pos_low_i),
  .neg_high_i     (neg_high_i),
  .ot_i           (ot_i),
  .pos_en_o       (pos_en_o),
  .neg_en_o       (neg_en_o),
  .rail_connect_o (rail_connect_o),
  .discharge_o    (discharge_o),
  .state_o        (state_o),
  .cause_o        (cause_o)
);

// File: tb/tb_supply_seq.sv
module tb_supply_seq;
  localparam int unsigned SD = 20;
  localparam int unsigned FQ = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0, ctrl_en_i = 1'b0, uvlo_i = 1'b0, aux_req_i = 1'b0;
  logic pos_low_i = 1'b0, neg_high_i = 1'b0, ot_i = 1'b0;
  logic pos_en_o, pos_softstart_o, neg_en_o, aux_en_o, rail_connect_o, discharge_o;
  logic [1:0] state_o, cause_o;

  always #2 clk = ~clk;

  supply_seq #(.START_TICKS(SD), .FAULT_TICKS(FQ)) dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .ctrl_en_i(ctrl_en_i), .uvlo_i(uvlo_i),
    .aux_req_i(aux_req_i), .pos_low_i(pos_low_i), .neg_high_i(neg_high_i), .ot_i(ot_i),
    .pos_en_o(pos_en_o), .pos_softstart_o(pos_softstart_o), .neg_en_o(neg_en_o),
    .aux_en_o(aux_en_o), .rail_connect_o(rail_connect_o), .discharge_o(discharge_o),
    .state_o(state_o), .cause_o(cause_o)
  );

  typedef struct {
    string      tag;
    logic [1:0] st;
    logic [1:0] cs;
    logic [5:0] bits; // pos, ss, neg, conn, dis, aux
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      logic [5:0] act;
      e = sb.pop_front();
      act = {pos_en_o, pos_softstart_o, neg_en_o, rail_connect_o, discharge_o, aux_en_o};
      checks++;
      if (state_o !== e.st || cause_o !== e.cs || act !== e.bits) begin
        errors++;
        $display("FAIL %s: actual state=%0d cause=%0d outs=%b expected state=%0d cause=%0d outs=%b",
                 e.tag, state_o, cause_o, act, e.st, e.cs, e.bits);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; step(1);
      tick_i = 1'b0; step(3);
    end
  endtask

  task automatic push(input string tag, input logic [1:0] st, input logic [1:0] cs, input logic aux);
    exp_t e;
    e.tag = tag; e.st = st; e.cs = cs;
    case (st)
      2'd0: e.bits = {5'b00001, aux};
      2'd1: e.bits = {5'b11010, aux};
      2'd2: e.bits = {5'b10110, aux};
      default: e.bits = {5'b00001, aux};
    endcase
    sb.push_back(e);
  endtask

  task automatic bring_up(input string tag);
    ctrl_en_i = 1'b0; step(1);
    ctrl_en_i = 1'b1; step(1);
    ticks(SD);
    push(tag, 2'd2, 2'd0, 1'b0);
  endtask

  initial begin
    step(3);
    rst = 1'b0; step(1);
    push("R1 reset off", 2'd0, 2'd0, 1'b0);

    ctrl_en_i = 1'b1; step(1);
    push("R2 start", 2'd1, 2'd0, 1'b0);
    ticks(SD - 1);
    push("R3 one tick short of delay", 2'd1, 2'd0, 1'b0);
    tick_i = 1'b1; step(1); tick_i = 1'b0;
    push("R3 negative rail on", 2'd2, 2'd0, 1'b0);

    pos_low_i = 1'b1; ticks(FQ - 1);
    push("R4 one tick short of trip", 2'd2, 2'd0, 1'b0);
    pos_low_i = 1'b0; step(1);
    pos_low_i = 1'b1; ticks(FQ - 1);
    push("R6 count restarted after drop", 2'd2, 2'd0, 1'b0);
    tick_i = 1'b1; step(1); tick_i = 1'b0;
    push("R4 positive low trip", 2'd3, 2'd1, 1'b0);
    pos_low_i = 1'b0; ticks(FQ + 2);
    push("R8 latch holds after flag clears", 2'd3, 2'd1, 1'b0);

    ctrl_en_i = 1'b0; step(1);
    push("R9 enable low clears", 2'd0, 2'd0, 1'b0);
    ctrl_en_i = 1'b1; step(1);
    push("R9 restart after toggle", 2'd1, 2'd0, 1'b0);
    ctrl_en_i = 1'b0; step(1);
    push("R9 enable low in start", 2'd0, 2'd0, 1'b0);

    bring_up("R3 running again");
    neg_high_i = 1'b1; ticks(FQ);
    push("R5 negative high trip", 2'd3, 2'd2, 1'b0);
    neg_high_i = 1'b0;

    uvlo_i = 1'b1; step(1);
    push("R10 uvlo clears latch", 2'd0, 2'd0, 1'b0);
    step(4);
    push("R10 start blocked under uvlo", 2'd0, 2'd0, 1'b0);
    uvlo_i = 1'b0; step(1);
    push("R10 start after uvlo release", 2'd1, 2'd0, 1'b0);

    ot_i = 1'b1; aux_req_i = 1'b1; step(1);
    push("R7 OT in start trips at once", 2'd3, 2'd3, 1'b0);
    ot_i = 1'b0; step(2);
    push("R11 aux held off by OT latch", 2'd3, 2'd3, 1'b0);
    ctrl_en_i = 1'b0; step(1);
    push("R11 aux follows request while off", 2'd0, 2'd0, 1'b1);
    uvlo_i = 1'b1; step(1);
    push("R11 aux off under uvlo", 2'd0, 2'd0, 1'b0);
    uvlo_i = 1'b0; aux_req_i = 1'b0; step(1);

    ctrl_en_i = 1'b1; step(1);
    pos_low_i = 1'b1; neg_high_i = 1'b1;
    ticks(SD - 1);
    push("R12 flags ignored in start", 2'd1, 2'd0, 1'b0);
    tick_i = 1'b1; step(1); tick_i = 1'b0;
    push("R12 reached running", 2'd2, 2'd0, 1'b0);
    ticks(FQ - 1);
    push("R12 start time not counted", 2'd2, 2'd0, 1'b0);
    tick_i = 1'b1; step(1); tick_i = 1'b0;
    push("R7 positive beats negative", 2'd3, 2'd1, 1'b0);
    pos_low_i = 1'b0; neg_high_i = 1'b0;

    bring_up("R3 running for priority");
    pos_low_i = 1'b1; neg_high_i = 1'b1; ticks(FQ - 1);
    ot_i = 1'b1; tick_i = 1'b1; step(1); tick_i = 1'b0;
    push("R7 OT beats rail faults", 2'd3, 2'd3, 1'b0);
    ot_i = 1'b0; pos_low_i = 1'b0; neg_high_i = 1'b0;
    ctrl_en_i = 1'b0; step(1);
    push("R1 off again", 2'd0, 2'd0, 1'b0);

    step(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule